// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one external machine cycle at a time on a bus with a 16-bit address whose low address byte shares eight lines with the data. A requester presents a cycle kind, an address and a write byte together with a one-cycle start strobe while the sequencer is idle. The sequencer then steps through its T-states. In the first T-state it presents the address and raises the address latch strobe. In the second it asserts the read or write strobe. It stretches the cycle with wait states for as long as the ready input is low. It finishes with a done pulse and, for reads, the captured byte.

An outside bus master may ask for the bus with a hold request. The request is granted only when the sequencer is between cycles: from idle, or straight after the last T-state of the cycle in flight. While the bus is granted, the address, shared lines and the read, write and memory/IO controls are all released. The address latch strobe stays driven low. Tri-state pins are modelled as value outputs with separate enable outputs, which the pad ring is expected to combine.

Top module: `bus_seq_top`

## Requirements
- R1: The cycle kind code is 0 = opcode fetch, 1 = memory read, 2 = memory write, 3 = I/O read, 4 = I/O write. During a cycle the status pair `busStatus[1:0]` is 2'b11 for a fetch, 2'b10 for either read and 2'b01 for either write. It is 2'b00 when idle or in hold.
- R2: With no wait states a fetch is busy for 4 clock cycles and every other kind for 3. `done` is high for exactly the last T-state of each cycle. `busy` is low only when idle.
- R3: In T1 `ale` is high for one clock, the shared lines are enabled and carry the low address byte, and `addrHi` is enabled with the high address byte. `addrHi` stays enabled and unchanged through the last T-state.
- R4: For reads (kinds 0, 1, 3) `rdN` is low in T2 and in every wait state, and high in T3. `rdData` takes the shared-line input at the clock edge that ends the last T2 or wait state. It holds that value until the next read.
- R5: For writes (kinds 2, 4) `wrN` is low in T2 and every wait state, and high in T3. The shared lines are enabled with the write byte exactly while `wrN` is low. In T3 the shared lines are released.
- R6: `ready` is sampled at the end of T2 and of each wait state. When it is low, one more wait state follows with every bus output unchanged. So a cycle with n low samples lasts n clocks longer and keeps its strobe low for n+1 clocks.
- R7: `ioM` is high during I/O cycles (kinds 3, 4) and low during memory cycles and fetches.
- R8: A hold request is acknowledged on the clock after idle, or on the clock after the last T-state of a running cycle, never inside a cycle. While `holdAck` is high, `addrHiOe`, `adOe` and `ctrlOe` are low and `ale` is driven low. Removing the request returns the block to idle on the next clock.
- R9: A start strobe is ignored when a hold request is present in the same idle cycle, while busy or in hold, or when the kind code is 5 to 7.
- R10: While reset is asserted the block is idle: `busy`, `done`, `holdAck`, `ale` low, `rdN` and `wrN` high, status 2'b00, `rdData` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Start strobe for one machine cycle |
| startKind | input | 3 | Cycle kind code (R1) |
| startAddr | input | 16 | Cycle address |
| startData | input | 8 | Byte to write |
| ready | input | 1 | Target ready; low inserts wait states |
| holdReq | input | 1 | Outside master requests the bus |
| adIn | input | 8 | Shared lines as seen at the pins |
| addrHi | output | 8 | High address byte |
| addrHiOe | output | 1 | Output enable of addrHi |
| adOut | output | 8 | Value driven onto the shared lines |
| adOe | output | 1 | Output enable of the shared lines |
| ale | output | 1 | Address latch strobe, always driven |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| ioM | output | 1 | High for I/O, low for memory |
| ctrlOe | output | 1 | Output enable of rdN, wrN and ioM |
| busStatus | output | 2 | Cycle status pair |
| holdAck | output | 1 | Bus granted to the outside master |
| rdData | output | 8 | Last byte read |
| done | output | 1 | Last T-state of a cycle |
| busy | output | 1 | Not idle |

## Verification
A hold request and the end of a cycle can land in the same clock. The request is raised while a read is stretched by wait states, so it is still pending when `done` fires. The grant must then appear on the very next clock, with no idle clock between and no T-state cut short. Hold and a start strobe can also meet in one idle clock. There the grant must win and no T1 may follow. A per-clock reference model compares every enable, strobe and bus value in both cases.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  typedef enum logic [2:0] {
    CYC_FETCH = 3'd0,
    CYC_MRD   = 3'd1,
    CYC_MWR   = 3'd2,
    CYC_IORD  = 3'd3,
    CYC_IOWR  = 3'd4
  } cycKind_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } tState_t;

  typedef struct packed {
    logic load;
    logic capture;
    logic aleOn;
    logic hiOe;
    logic loAddrOe;
    logic loDataOe;
    logic rdOn;
    logic wrOn;
    logic ctrlOe;
    logic cycOn;
  } busStrobe_t;

  function automatic logic kindIsRead(cycKind_t k);
    return (k == CYC_FETCH) || (k == CYC_MRD) || (k == CYC_IORD);
  endfunction

  function automatic logic kindIsWrite(cycKind_t k);
    return (k == CYC_MWR) || (k == CYC_IOWR);
  endfunction

  function automatic logic kindIsIo(cycKind_t k);
    return (k == CYC_IORD) || (k == CYC_IOWR);
  endfunction

endpackage

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
  import bus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [2:0] startKind,
  input  logic       ready,
  input  logic       holdReq,
  input  cycKind_t   curKind,
  output busStrobe_t strobe,
  output logic       holdAck,
  output logic       done,
  output logic       busy
);

  tState_t stateQ, stateD;
  logic    kindOk;
  logic    isFetch, isRead, isWrite;
  logic    inStrobe;
  logic    inCycle;

  assign kindOk  = (startKind <= 3'(CYC_IOWR));
  assign isFetch = (curKind == CYC_FETCH);
  assign isRead  = kindIsRead(curKind);
  assign isWrite = kindIsWrite(curKind);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (holdReq)                 stateD = ST_HOLD;
        else if (startReq && kindOk) stateD = ST_T1;
      end
      ST_T1:        stateD = ST_T2;
      ST_T2, ST_TW: stateD = ready ? ST_T3 : ST_TW;
      ST_T3: begin
        if (isFetch)      stateD = ST_T4;
        else if (holdReq) stateD = ST_HOLD;
        else              stateD = ST_IDLE;
      end
      ST_T4:   stateD = holdReq ? ST_HOLD : ST_IDLE;
      ST_HOLD: stateD = holdReq ? ST_HOLD : ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign inStrobe = (stateQ == ST_T2) || (stateQ == ST_TW);
  assign inCycle  = (stateQ == ST_T1) || inStrobe ||
                    (stateQ == ST_T3) || (stateQ == ST_T4);

  always_comb begin
    strobe          = '0;
    strobe.load     = (stateQ == ST_IDLE) && !holdReq && startReq && kindOk;
    strobe.capture  = inStrobe && ready && isRead;
    strobe.aleOn    = (stateQ == ST_T1);
    strobe.hiOe     = inCycle;
    strobe.cycOn    = inCycle;
    strobe.loAddrOe = (stateQ == ST_T1);
    strobe.loDataOe = inStrobe && isWrite;
    strobe.rdOn     = inStrobe && isRead;
    strobe.wrOn     = inStrobe && isWrite;
    strobe.ctrlOe   = (stateQ != ST_HOLD);
  end

  assign holdAck = (stateQ == ST_HOLD);
  assign done    = ((stateQ == ST_T3) && !isFetch) || (stateQ == ST_T4);
  assign busy    = (stateQ != ST_IDLE);

endmodule

// File: rtl/bus_seq_dp.sv
module bus_seq_dp
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobe_t           strobe,
  input  logic [2:0]           startKind,
  input  logic [ADDR_W-1:0]    startAddr,
  input  logic [DATA_W-1:0]    startData,
  input  logic [DATA_W-1:0]    adIn,
  output cycKind_t             curKind,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic                 addrHiOe,
  output logic [DATA_W-1:0]    adOut,
  output logic                 adOe,
  output logic                 ale,
  output logic                 rdN,
  output logic                 wrN,
  output logic                 ioM,
  output logic                 ctrlOe,
  output logic [1:0]           busStatus,
  output logic [DATA_W-1:0]    rdData
);

  localparam int HI_W = ADDR_W - DATA_W;

  cycKind_t          kindQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wrQ;
  logic [DATA_W-1:0] rdQ;
  logic [1:0]        statusOfKind;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ <= CYC_FETCH;
      addrQ <= '0;
      wrQ   <= '0;
    end else if (strobe.load) begin
      kindQ <= cycKind_t'(startKind);
      addrQ <= startAddr;
      wrQ   <= startData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdQ <= '0;
    else if (strobe.capture) rdQ <= adIn;
  end

  always_comb begin
    if (kindQ == CYC_FETCH)      statusOfKind = 2'b11;
    else if (kindIsRead(kindQ))  statusOfKind = 2'b10;
    else if (kindIsWrite(kindQ)) statusOfKind = 2'b01;
    else                         statusOfKind = 2'b00;
  end

  always_comb begin
    if (strobe.loAddrOe)      adOut = addrQ[DATA_W-1:0];
    else if (strobe.loDataOe) adOut = wrQ;
    else                      adOut = '0;
  end

  assign curKind   = kindQ;
  assign addrHi    = addrQ[ADDR_W-1 -: HI_W];
  assign addrHiOe  = strobe.hiOe;
  assign adOe      = strobe.loAddrOe || strobe.loDataOe;
  assign ale       = strobe.aleOn;
  assign rdN       = !strobe.rdOn;
  assign wrN       = !strobe.wrOn;
  assign ioM       = strobe.cycOn && kindIsIo(kindQ);
  assign ctrlOe    = strobe.ctrlOe;
  assign busStatus = strobe.cycOn ? statusOfKind : 2'b00;
  assign rdData    = rdQ;

endmodule

// File: rtl/bus_seq_top.sv
module bus_seq_top
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startReq,
  input  logic [2:0]               startKind,
  input  logic [ADDR_W-1:0]        startAddr,
  input  logic [DATA_W-1:0]        startData,
  input  logic                     ready,
  input  logic                     holdReq,
  input  logic [DATA_W-1:0]        adIn,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic                     addrHiOe,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     ioM,
  output logic                     ctrlOe,
  output logic [1:0]               busStatus,
  output logic                     holdAck,
  output logic [DATA_W-1:0]        rdData,
  output logic                     done,
  output logic                     busy
);

  busStrobe_t strobe;
  cycKind_t   curKind;

  bus_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .startKind (startKind),
    .ready     (ready),
    .holdReq   (holdReq),
    .curKind   (curKind),
    .strobe    (strobe),
    .holdAck   (holdAck),
    .done      (done),
    .busy      (busy)
  );

  bus_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startKind (startKind),
    .startAddr (startAddr),
    .startData (startData),
    .adIn      (adIn),
    .curKind   (curKind),
    .addrHi    (addrHi),
    .addrHiOe  (addrHiOe),
    .adOut     (adOut),
    .adOe      (adOe),
    .ale       (ale),
    .rdN       (rdN),
    .wrN       (wrN),
    .ioM       (ioM),
    .ctrlOe    (ctrlOe),
    .busStatus (busStatus),
    .rdData    (rdData)
  );

endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk #(
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            ready,
  input logic [HI_W-1:0] addrHi,
  input logic            addrHiOe,
  input logic            adOe,
  input logic            ale,
  input logic            rdN,
  input logic            wrN,
  input logic            ctrlOe,
  input logic [1:0]      busStatus,
  input logic            holdAck,
  input logic            done,
  input logic            busy
);

  AST_STATUS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> busStatus == 2'b00); // R1

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R2

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale && addrHiOe); // R3

  AST_RD_AFTER_ALE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |-> $past(ale)); // R4

  AST_WR_DRIVES_DATA: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> adOe && addrHiOe); // R5

  AST_WAIT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && !ready) |=> !rdN && $stable(addrHi)); // R6

  AST_HOLD_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> !addrHiOe && !adOe && !ctrlOe && !ale); // R8

  AST_HOLD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> ($past(done) || !$past(busy))); // R8

endmodule

bind bus_seq_top bus_seq_chk #(.HI_W(ADDR_W - DATA_W)) chk (
  .clk       (clk),
  .rstN      (rstN),
  .ready     (ready),
  .addrHi    (addrHi),
  .addrHiOe  (addrHiOe),
  .adOe      (adOe),
  .ale       (ale),
  .rdN       (rdN),
  .wrN       (wrN),
  .ctrlOe    (ctrlOe),
  .busStatus (busStatus),
  .holdAck   (holdAck),
  .done      (done),
  .busy      (busy)
);

// File: tb/bus_seq_top_test.sv
module bus_seq_top_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [2:0]  startKind = 3'd0;
  logic [15:0] startAddr = 16'h0;
  logic [7:0]  startData = 8'h0;
  logic        ready = 1'b1;
  logic        holdReq = 1'b0;
  logic [7:0]  adIn;
  logic [7:0]  addrHi;
  logic        addrHiOe;
  logic [7:0]  adOut;
  logic        adOe;
  logic        ale;
  logic        rdN;
  logic        wrN;
  logic        ioM;
  logic        ctrlOe;
  logic [1:0]  busStatus;
  logic        holdAck;
  logic [7:0]  rdData;
  logic        done;
  logic        busy;

  int checks = 0;
  int failures = 0;
  int waitBudget = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_seq_top uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startKind(startKind),
    .startAddr(startAddr), .startData(startData), .ready(ready),
    .holdReq(holdReq), .adIn(adIn), .addrHi(addrHi), .addrHiOe(addrHiOe),
    .adOut(adOut), .adOe(adOe), .ale(ale), .rdN(rdN), .wrN(wrN), .ioM(ioM),
    .ctrlOe(ctrlOe), .busStatus(busStatus), .holdAck(holdAck),
    .rdData(rdData), .done(done), .busy(busy)
  );

  function automatic logic [7:0] memByte(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic bit kRd(logic [2:0] k);
    return k == 3'd0 || k == 3'd1 || k == 3'd3;
  endfunction

  function automatic bit kWr(logic [2:0] k);
    return k == 3'd2 || k == 3'd4;
  endfunction

  // Reference model: phase 0 idle, 1 first, 2 strobe, 3 wait, 4 third,
  // 5 fourth, 6 granted
  int          mPh = 0;
  logic [2:0]  mKind = 3'd0;
  logic [15:0] mAddr = 16'h0;
  logic [7:0]  mWr = 8'h0;
  logic [7:0]  mRd = 8'h0;

  assign adIn = rdN ? 8'hEE : memByte(mAddr);

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mRd = 8'h0;
    end else begin
      case (mPh)
        0: if (holdReq) mPh = 6;
           else if (startReq && startKind <= 3'd4) begin
             mKind = startKind; mAddr = startAddr; mWr = startData; mPh = 1;
           end
        1: mPh = 2;
        2, 3: if (ready) begin
                if (kRd(mKind)) mRd = memByte(mAddr);
                mPh = 4;
              end else mPh = 3;
        4: mPh = (mKind == 3'd0) ? 5 : (holdReq ? 6 : 0);
        5: mPh = holdReq ? 6 : 0;
        default: mPh = holdReq ? 6 : 0;
      endcase
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit inCyc = (mPh >= 1 && mPh <= 5);
    bit inStb = (mPh == 2 || mPh == 3);
    bit eAdOe = (mPh == 1) || (inStb && kWr(mKind));
    int eSt = !inCyc ? 0 : (mKind == 3'd0) ? 3 : kRd(mKind) ? 2 : 1;
    chk("R3", "ale", ale, mPh == 1);
    chk("R3", "addrHiOe", addrHiOe, inCyc);
    if (inCyc) chk("R3", "addrHi", addrHi, mAddr[15:8]);
    chk("R5", "adOe", adOe, eAdOe);
    if (mPh == 1) chk("R3", "adOut addr", adOut, mAddr[7:0]);
    if (eAdOe && mPh != 1) chk("R5", "adOut data", adOut, mWr);
    chk("R8", "ctrlOe", ctrlOe, mPh != 6);
    if (mPh != 6) begin
      chk("R4", "rdN", rdN, !(inStb && kRd(mKind)));
      chk("R5", "wrN", wrN, !(inStb && kWr(mKind)));
      chk("R7", "ioM", ioM, inCyc && (mKind == 3'd3 || mKind == 3'd4));
    end
    chk("R1", "busStatus", busStatus, eSt);
    chk("R8", "holdAck", holdAck, mPh == 6);
    chk("R2", "done", done, (mPh == 4 && mKind != 3'd0) || mPh == 5);
    chk("R2", "busy", busy, mPh != 0);
    chk("R4", "rdData", rdData, mRd);
  endtask

  task automatic tick();
    @(negedge clk);
    if (rstN) compareAll();
    if ((!rdN || !wrN) && waitBudget > 0) begin
      ready = 1'b0; waitBudget--;
    end else ready = 1'b1;
  endtask

  task automatic doCycle(logic [2:0] k, logic [15:0] a, logic [7:0] d, int w);
    int len = 0;
    int low = 0;
    while (busy) tick();
    startReq = 1'b1; startKind = k; startAddr = a; startData = d;
    waitBudget = w;
    tick();
    startReq = 1'b0;
    while (busy && !holdAck) begin
      len++;
      if (!rdN || !wrN) low++;
      tick();
    end
    chk("R2", "cycle length", len, ((k == 3'd0) ? 4 : 3) + w);
    chk("R6", "strobe low clocks", low, 1 + w);
    if (kRd(k)) chk("R4", "read byte", rdData, memByte(a));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "busy", busy, 0);
    chk("R10", "done", done, 0);
    chk("R10", "holdAck", holdAck, 0);
    chk("R10", "ale", ale, 0);
    chk("R10", "rdN", rdN, 1);
    chk("R10", "wrN", wrN, 1);
    chk("R10", "status", busStatus, 0);
    chk("R10", "rdData", rdData, 0);
    rstN = 1'b1;
    tick();

    doCycle(3'd0, 16'h4003, 8'h00, 0);
    doCycle(3'd1, 16'h12A5, 8'h00, 2);
    doCycle(3'd2, 16'h8001, 8'hC3, 0);
    doCycle(3'd2, 16'hFFFF, 8'h5A, 3);
    doCycle(3'd3, 16'h0077, 8'h00, 1);
    doCycle(3'd4, 16'h00F0, 8'h81, 0);
    doCycle(3'd0, 16'h0000, 8'h00, 4);

    // R9 invalid kind ignored
    startReq = 1'b1; startKind = 3'd6; startAddr = 16'hBEEF;
    tick();
    startReq = 1'b0;
    chk("R9", "busy after invalid kind", busy, 0);
    chk("R9", "ale after invalid kind", ale, 0);
    tick();

    // R9 start during a running cycle ignored
    startReq = 1'b1; startKind = 3'd1; startAddr = 16'h2222; waitBudget = 1;
    tick();
    startKind = 3'd2; startAddr = 16'h9999;
    tick();
    startReq = 1'b0;
    while (busy) tick();
    chk("R9", "read byte unchanged by late start", rdData, memByte(16'h2222));
    tick();
    chk("R9", "no second cycle", busy, 0);

    // R8/R9 hold and start in the same idle clock
    holdReq = 1'b1; startReq = 1'b1; startKind = 3'd0; startAddr = 16'h3333;
    tick();
    startReq = 1'b0;
    chk("R9", "hold wins over start", holdAck, 1);
    chk("R8", "shared lines released", adOe, 0);
    startReq = 1'b1;
    tick(); tick();
    startReq = 1'b0;
    holdReq = 1'b0;
    tick();
    chk("R8", "idle after release", busy, 0);
    chk("R9", "start in hold ignored", ale, 0);

    // R8 hold raised during a stretched read, granted right after done
    startReq = 1'b1; startKind = 3'd3; startAddr = 16'h5A10; waitBudget = 2;
    tick();
    startReq = 1'b0;
    while (rdN) tick();
    holdReq = 1'b1;
    while (!done) begin
      chk("R8", "no grant inside cycle", holdAck, 0);
      tick();
    end
    tick();
    chk("R8", "grant after done", holdAck, 1);
    chk("R4", "read completed before grant", rdData, memByte(16'h5A10));
    tick(); tick();
    holdReq = 1'b0;
    tick();
    chk("R8", "bus back", ctrlOe, 1);

    // hold at the end of a fetch
    startReq = 1'b1; startKind = 3'd0; startAddr = 16'h7F7F; waitBudget = 0;
    tick();
    startReq = 1'b0;
    holdReq = 1'b1;
    while (!done) tick();
    tick();
    chk("R8", "grant after fetch", holdAck, 1);
    holdReq = 1'b0;
    tick();

    for (int i = 0; i < 40; i++) begin
      doCycle(3'(i % 5), 16'(i * 16'h0713 + 16'h0101), 8'(i * 37), i % 4);
    end

    tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule